// File: doc/BRIEF.md
# 64-to-32 Bit Burst Write Master

This block is the initiating side of write bursts on a 32-bit multiplexed address/data bus whose control lines are active low. A local agent supplies 64-bit words with 8 byte enables. The block sends each word as two bus data phases: first the lower 32 bits with the lower four byte enables, then the upper 32 bits with the upper four. When the agent asks for it, the block can also open the burst with two address phases, so that targets above the 4 GB boundary can be reached even though the bus is only 32 bits wide.

A burst begins with a one-cycle `start` pulse that carries the address, the number of 64-bit words and the 64-bit-addressing request. The block drives the address phase or phases and then waits out the turnaround. It raises initiator-ready only after it has seen both device-select from the target and ready from the local side. From then on it moves one half-word per completed data phase, and wait states come from target-ready. Two take strobes tell the local agent which half has just been placed on the bus. A word must stay stable on the local inputs until its high half has been taken. A counter shows how many data phases are left. On the final phase the block drops frame, and after that phase completes it releases the bus and reports a normal termination.

Top module: `wrbm_burst_master`

## Requirements
- R1: After reset, `frame_n`, `irdy_n`, `req64_n`, `lo_take_n` and `hi_take_n` are 1. `frame_oe`, `irdy_oe`, `ad_oe` and `cbe_oe` are 0, `status` is 0 (idle), `term_type` is 0 and `phases_left` is 0.
- R2: A `start` pulse with `dac_req`=0 and `words`>0, given while the block is idle, leads in the next cycle to one address phase: `frame_n`=0, `req64_n`=0, `ad_out`=`addr[31:0]`, `cbe_out`=4'b0111 (memory write) and `status`=1.
- R3: With `dac_req`=1, the first address phase carries `addr[31:0]` with `cbe_out`=4'b1101. It is followed at once by a second address phase that carries `addr[63:32]` with `cbe_out`=4'b0111, and `status` stays 1 during both.
- R4: `irdy_n` first falls in the cycle after a cycle in which `devsel_n` and `lcl_rdy_n` were both 0. Until then `irdy_n` stays 1 and `status` is 2.
- R5: The bus carries the words in order, with each word's `lcl_data[31:0]`/`lcl_be[3:0]` before its `lcl_data[63:32]`/`lcl_be[7:4]`. `lo_take_n` is 0 for one cycle each time a low half appears on the bus. `hi_take_n` is 0 for one cycle each time a high half other than the final one appears. The two strobes are never 0 together.
- R6: In a data cycle with `trdy_n`=1, the next cycle holds `ad_out`, `cbe_out` and `phases_left` unchanged, and both take strobes are 1.
- R7: `phases_left` is loaded with twice `words` by the start pulse. It decreases by exactly one in the cycle after each cycle in which `irdy_n` and `trdy_n` are both 0.
- R8: During the final data phase (`phases_left`=1), `frame_n` and `req64_n` are 1 while `irdy_n` is 0, and both take strobes are 1. In every earlier data phase `frame_n` is 0.
- R9: In the cycle after the final phase completes, `frame_oe`, `ad_oe` and `cbe_oe` are 0, `irdy_n` is 1 with `irdy_oe` still 1, and `phases_left` is 0. One cycle later `irdy_oe` is 0.
- R10: `status` codes are 0 idle, 1 address, 2 turnaround/data, 3 bus termination. `term_type` is 1 (normal) while `status` is 3 and 0 otherwise. `status` stays 3 after a burst until the next accepted start.
- R11: A `start` pulse with `words`=0 is ignored: the bus stays released and `status` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle burst request |
| addr | input | 64 | Burst start address |
| words | input | 8 | Number of 64-bit words in the burst |
| dac_req | input | 1 | Use two address phases (64-bit addressing) |
| lcl_data | input | 64 | Current local word |
| lcl_be | input | 8 | Byte enables of the current local word, active low |
| lcl_rdy_n | input | 1 | Local side ready, active low |
| lo_take_n | output | 1 | Low half just placed on the bus, active low |
| hi_take_n | output | 1 | High half just placed on the bus, active low |
| ad_out | output | 32 | Address/data driven onto the bus |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| cbe_out | output | 4 | Command / byte enables driven onto the bus |
| cbe_oe | output | 1 | Drive enable for `cbe_out` |
| frame_n | output | 1 | Frame, active low |
| frame_oe | output | 1 | Drive enable for `frame_n` and `req64_n` |
| irdy_n | output | 1 | Initiator ready, active low |
| irdy_oe | output | 1 | Drive enable for `irdy_n` |
| req64_n | output | 1 | 64-bit transfer request, active low |
| devsel_n | input | 1 | Target device select, active low |
| trdy_n | input | 1 | Target ready, active low |
| phases_left | output | 9 | Remaining data phases |
| status | output | 4 | Transaction state code |
| term_type | output | 2 | Termination type, valid when `status` is 3 |

## Verification
The hardest cases to reach are the ones where a target stall and the local word boundary land on each other. A stall can fall on the phase that carries a high half, or on the phase just before the final one, where frame is about to drop. The stimulus reaches these cases with target-ready patterns tied to the data-cycle count, so stalls land on both halves and next to the last phase. It also delays device-select and local-ready by different amounts so that each one in turn is the input that holds initiator-ready back. The local model moves to the next word only on the high take strobe, so a strobe out of place shows up as wrong data on the scoreboard.

// File: rtl/wrbm_pkg.sv
`timescale 1ns/1ps
package wrbm_pkg;

   typedef enum logic [3:0] {
      ST_IDLE = 4'd0,
      ST_ADDR = 4'd1,
      ST_DATA = 4'd2,
      ST_TERM = 4'd3
   } wr_status_e;

   typedef enum logic [1:0] {
      TT_NONE   = 2'd0,
      TT_NORMAL = 2'd1
   } term_e;

   typedef enum logic [2:0] {
      F_IDLE,
      F_ADR_LO,
      F_ADR_HI,
      F_TURN,
      F_DATA,
      F_END
   } fsm_e;

   localparam logic [3:0] CMD_MEMW = 4'b0111;
   localparam logic [3:0] CMD_DAC  = 4'b1101;

endpackage

// File: rtl/wrbm_phase_ctr.sv
`timescale 1ns/1ps
module wrbm_phase_ctr #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic [CNT_W-1:0] cnt,
   output logic             last,
   output logic             next_last
);

   if (CNT_W < 2) begin : g_chk_w
      $error("wrbm_phase_ctr: CNT_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (dec)
         cnt <= cnt - CNT_W'(1);
   end

   assign last      = (cnt == CNT_W'(1));
   assign next_last = (cnt == CNT_W'(2));

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> cnt != '0);  // R7

endmodule

// File: rtl/wrbm_half_mux.sv
`timescale 1ns/1ps
module wrbm_half_mux #(
   parameter int BUS_W = 32,
   parameter int BE_W  = 4
) (
   input  logic [2*BUS_W-1:0] word,
   input  logic [2*BE_W-1:0]  be,
   input  logic               sel_hi,
   output logic [BUS_W-1:0]   half,
   output logic [BE_W-1:0]    half_be
);

   if (BE_W * 8 != BUS_W) begin : g_chk_be
      $error("wrbm_half_mux: one byte enable per byte lane required");
   end

   assign half    = sel_hi ? word[2*BUS_W-1:BUS_W] : word[BUS_W-1:0];
   assign half_be = sel_hi ? be[2*BE_W-1:BE_W]     : be[BE_W-1:0];

endmodule

// File: rtl/wrbm_burst_master.sv
`timescale 1ns/1ps
module wrbm_burst_master
   import wrbm_pkg::*;
#(
   parameter int BUS_W   = 32,
   parameter int WORDS_W = 8,
   parameter bit DAC_EN  = 1'b1,
   localparam int LCL_W  = 2 * BUS_W,
   localparam int BE_W   = BUS_W / 8,
   localparam int LBE_W  = 2 * BE_W,
   localparam int CNT_W  = WORDS_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [LCL_W-1:0]   addr,
   input  logic [WORDS_W-1:0] words,
   input  logic               dac_req,
   input  logic [LCL_W-1:0]   lcl_data,
   input  logic [LBE_W-1:0]   lcl_be,
   input  logic               lcl_rdy_n,
   output logic               lo_take_n,
   output logic               hi_take_n,
   output logic [BUS_W-1:0]   ad_out,
   output logic               ad_oe,
   output logic [BE_W-1:0]    cbe_out,
   output logic               cbe_oe,
   output logic               frame_n,
   output logic               frame_oe,
   output logic               irdy_n,
   output logic               irdy_oe,
   output logic               req64_n,
   input  logic               devsel_n,
   input  logic               trdy_n,
   output logic [CNT_W-1:0]   phases_left,
   output logic [3:0]         status,
   output logic [1:0]         term_type
);

   if (BUS_W % 8 != 0) begin : g_chk_lanes
      $error("wrbm_burst_master: BUS_W must be a whole number of bytes");
   end
   if (BUS_W < 32) begin : g_chk_cmd
      $error("wrbm_burst_master: BUS_W must hold a 4-bit command");
   end
   if (WORDS_W < 1) begin : g_chk_words
      $error("wrbm_burst_master: WORDS_W must be positive");
   end

   localparam logic [BE_W-1:0] CBE_MEMW = BE_W'(CMD_MEMW);
   localparam logic [BE_W-1:0] CBE_DAC  = BE_W'(CMD_DAC);

   fsm_e              fsm_q;
   wr_status_e        stat_q;
   term_e             term_q;
   logic              cur_hi_q;
   logic              dac_q;
   logic [BUS_W-1:0]  addr_hi_q;
   logic              use_dac;
   logic              accept;
   logic              complete;
   logic              ctr_last;
   logic              ctr_next_last;
   logic              mux_sel;
   logic [BUS_W-1:0]  mux_half;
   logic [BE_W-1:0]   mux_be;

   if (DAC_EN) begin : g_dac
      assign use_dac = dac_req;
   end else begin : g_nodac
      assign use_dac = 1'b0;
   end

   assign accept   = (fsm_q == F_IDLE) && start && (words != '0);
   assign complete = (fsm_q == F_DATA) && !trdy_n;
   assign mux_sel  = (fsm_q == F_DATA) ? !cur_hi_q : 1'b0;

   wrbm_phase_ctr #(.CNT_W(CNT_W)) i_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .load_val  ({words, 1'b0}),
      .dec       (complete),
      .cnt       (phases_left),
      .last      (ctr_last),
      .next_last (ctr_next_last)
   );

   wrbm_half_mux #(.BUS_W(BUS_W), .BE_W(BE_W)) i_mux (
      .word    (lcl_data),
      .be      (lcl_be),
      .sel_hi  (mux_sel),
      .half    (mux_half),
      .half_be (mux_be)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsm_q     <= F_IDLE;
         stat_q    <= ST_IDLE;
         term_q    <= TT_NONE;
         cur_hi_q  <= 1'b0;
         dac_q     <= 1'b0;
         addr_hi_q <= '0;
         ad_out    <= '0;
         ad_oe     <= 1'b0;
         cbe_out   <= '0;
         cbe_oe    <= 1'b0;
         frame_n   <= 1'b1;
         frame_oe  <= 1'b0;
         irdy_n    <= 1'b1;
         irdy_oe   <= 1'b0;
         req64_n   <= 1'b1;
         lo_take_n <= 1'b1;
         hi_take_n <= 1'b1;
      end else begin
         lo_take_n <= 1'b1;
         hi_take_n <= 1'b1;
         unique case (fsm_q)
            F_IDLE: begin
               if (accept) begin
                  fsm_q     <= F_ADR_LO;
                  stat_q    <= ST_ADDR;
                  term_q    <= TT_NONE;
                  dac_q     <= use_dac;
                  addr_hi_q <= addr[LCL_W-1:BUS_W];
                  ad_out    <= addr[BUS_W-1:0];
                  ad_oe     <= 1'b1;
                  cbe_out   <= use_dac ? CBE_DAC : CBE_MEMW;
                  cbe_oe    <= 1'b1;
                  frame_n   <= 1'b0;
                  frame_oe  <= 1'b1;
                  req64_n   <= 1'b0;
               end
            end
            F_ADR_LO: begin
               if (dac_q) begin
                  fsm_q   <= F_ADR_HI;
                  ad_out  <= addr_hi_q;
                  cbe_out <= CBE_MEMW;
               end else begin
                  fsm_q  <= F_TURN;
                  stat_q <= ST_DATA;
               end
            end
            F_ADR_HI: begin
               fsm_q  <= F_TURN;
               stat_q <= ST_DATA;
            end
            F_TURN: begin
               if (!devsel_n && !lcl_rdy_n) begin
                  fsm_q     <= F_DATA;
                  irdy_n    <= 1'b0;
                  irdy_oe   <= 1'b1;
                  ad_out    <= mux_half;
                  cbe_out   <= mux_be;
                  cur_hi_q  <= 1'b0;
                  lo_take_n <= 1'b0;
               end
            end
            F_DATA: begin
               if (!trdy_n) begin
                  if (ctr_last) begin
                     fsm_q    <= F_END;
                     stat_q   <= ST_TERM;
                     term_q   <= TT_NORMAL;
                     irdy_n   <= 1'b1;
                     frame_n  <= 1'b1;
                     frame_oe <= 1'b0;
                     req64_n  <= 1'b1;
                     ad_oe    <= 1'b0;
                     cbe_oe   <= 1'b0;
                  end else begin
                     ad_out   <= mux_half;
                     cbe_out  <= mux_be;
                     cur_hi_q <= !cur_hi_q;
                     if (ctr_next_last) begin
                        frame_n <= 1'b1;
                        req64_n <= 1'b1;
                     end else if (cur_hi_q) begin
                        lo_take_n <= 1'b0;
                     end else begin
                        hi_take_n <= 1'b0;
                     end
                  end
               end
            end
            F_END: begin
               fsm_q   <= F_IDLE;
               irdy_oe <= 1'b0;
            end
            default: fsm_q <= F_IDLE;
         endcase
      end
   end

   assign status    = stat_q;
   assign term_type = term_q;

   AST_STROBE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (!lo_take_n || !hi_take_n) |-> (!irdy_n && !frame_n && !(!lo_take_n && !hi_take_n)));  // R5

   AST_IRDY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irdy_n) |-> $past(!devsel_n && !lcl_rdy_n));  // R4

   AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!irdy_n && trdy_n) |=> ($stable(ad_out) && $stable(cbe_out) && $stable(phases_left) && lo_take_n && hi_take_n));  // R6

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!irdy_n && !trdy_n) |=> (phases_left == $past(phases_left) - CNT_W'(1)));  // R7

   AST_LAST_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      (!irdy_n && frame_n) |-> (req64_n && lo_take_n && hi_take_n && phases_left == CNT_W'(1)));  // R8

   AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (!irdy_n && !trdy_n && frame_n) |=> (!frame_oe && !ad_oe && !cbe_oe && irdy_n && irdy_oe && phases_left == '0));  // R9

   AST_TERM_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      (status != ST_TERM) |-> (term_type == TT_NONE));  // R10

endmodule

// File: tb/test_wrbm_burst_master.sv
`timescale 1ns/1ps
module test_wrbm_burst_master;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [63:0] addr = '0;
   logic [7:0]  words = '0;
   logic        dac_req = 1'b0;
   logic [63:0] lcl_data;
   logic [7:0]  lcl_be;
   logic        lcl_rdy_n = 1'b1;
   logic        lo_take_n, hi_take_n;
   logic [31:0] ad_out;
   logic        ad_oe;
   logic [3:0]  cbe_out;
   logic        cbe_oe, frame_n, frame_oe, irdy_n, irdy_oe, req64_n;
   logic        devsel_n = 1'b1;
   logic        trdy_n = 1'b1;
   logic [8:0]  phases_left;
   logic [3:0]  status;
   logic [1:0]  term_type;

   always #2.5 clk = ~clk;

   wrbm_burst_master i_wrbm_burst_master (
      .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .words(words),
      .dac_req(dac_req), .lcl_data(lcl_data), .lcl_be(lcl_be), .lcl_rdy_n(lcl_rdy_n),
      .lo_take_n(lo_take_n), .hi_take_n(hi_take_n), .ad_out(ad_out), .ad_oe(ad_oe),
      .cbe_out(cbe_out), .cbe_oe(cbe_oe), .frame_n(frame_n), .frame_oe(frame_oe),
      .irdy_n(irdy_n), .irdy_oe(irdy_oe), .req64_n(req64_n), .devsel_n(devsel_n),
      .trdy_n(trdy_n), .phases_left(phases_left), .status(status), .term_type(term_type)
   );

   int total = 0;
   int fails = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // local word store, advanced by the high take strobe
   logic [63:0] wmem [16];
   logic [7:0]  bmem [16];
   int          widx = 0;
   assign lcl_data = wmem[widx[3:0]];
   assign lcl_be   = bmem[widx[3:0]];

   always begin
      @(negedge clk);
      #1;
      if (rst_n && !hi_take_n) widx++;
   end

   // scoreboard
   typedef struct {
      logic [31:0] d;
      logic [3:0]  be;
   } exp_t;
   exp_t sb_q[$];

   always begin
      @(negedge clk);
      #2;
      if (rst_n && !irdy_n && !trdy_n) begin
         if (sb_q.size() == 0) begin
            chk(1'b0, "R5 unexpected phase", {28'd0, cbe_out, ad_out}, 64'd0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            chk(ad_out == e.d && cbe_out == e.be, "R5 data order",
                {28'd0, cbe_out, ad_out}, {28'd0, e.be, e.d});
         end
      end
   end

   task automatic run_burst(input logic [63:0] a, input int nw, input bit dac,
                            input int wmode, input int dev_w, input int lcl_w, input logic [31:0] seed);
      int  cyc;
      bit  done;
      bit  prev_data;
      bit  prev_tr;
      logic [31:0] prev_ad;
      logic [8:0]  prev_cnt;
      int  nlo, nhi;
      bit  first;
      for (int i = 0; i < nw; i++) begin
         wmem[i] = {seed ^ (32'h1111_1111 * i), ~seed + 32'(i)};
         bmem[i] = 8'h5A ^ 8'(i) ^ seed[7:0];
         sb_q.push_back('{wmem[i][31:0], bmem[i][3:0]});
         sb_q.push_back('{wmem[i][63:32], bmem[i][7:4]});
      end
      widx = 0;
      @(negedge clk); #1;
      start = 1'b1; addr = a; words = 8'(nw); dac_req = dac;
      devsel_n = 1'b1; lcl_rdy_n = 1'b1; trdy_n = 1'b1;
      @(negedge clk); #1;
      chk(!frame_n && !req64_n && frame_oe, "R2 frame/req64 in address phase", {62'd0, frame_n, req64_n}, 64'd0);
      chk(ad_out == a[31:0], dac ? "R3 low address" : "R2 address", {32'd0, ad_out}, {32'd0, a[31:0]});
      chk(cbe_out == (dac ? 4'b1101 : 4'b0111), dac ? "R3 dual address command" : "R2 write command",
          {60'd0, cbe_out}, {60'd0, (dac ? 4'b1101 : 4'b0111)});
      chk(status == 4'd1, "R10 address status", {60'd0, status}, 64'd1);
      chk(phases_left == 9'(2 * nw), "R7 counter load", {55'd0, phases_left}, 64'(2 * nw));
      start = 1'b0;
      if (dac) begin
         @(negedge clk); #1;
         chk(ad_out == a[63:32] && cbe_out == 4'b0111 && status == 4'd1, "R3 high address phase",
             {28'd0, cbe_out, ad_out}, {28'd0, 4'b0111, a[63:32]});
      end
      for (int k = 0; k < ((dev_w > lcl_w) ? dev_w : lcl_w); k++) begin
         @(negedge clk); #1;
         chk(irdy_n && status == 4'd2, "R4 irdy held in turnaround", {59'd0, irdy_n, status}, {59'd0, 1'b1, 4'd2});
         if (k >= dev_w - 1) devsel_n = 1'b0;
         if (k >= lcl_w - 1) lcl_rdy_n = 1'b0;
      end
      cyc = 0; done = 1'b0; prev_data = 1'b0; prev_tr = 1'b1; prev_ad = '0; prev_cnt = '0;
      nlo = 0; nhi = 0; first = 1'b1;
      while (!done) begin
         @(negedge clk); #1;
         if (!irdy_n) begin
            if (first) begin
               chk(!lo_take_n && ad_out == wmem[0][31:0], "R4 irdy after devsel and local ready",
                   {31'd0, lo_take_n, ad_out}, {32'd0, wmem[0][31:0]});
               first = 1'b0;
            end
            if (!lo_take_n) nlo++;
            if (!hi_take_n) nhi++;
            chk(lo_take_n || hi_take_n, "R5 strobes exclusive", {62'd0, lo_take_n, hi_take_n}, 64'd1);
            if (prev_data && prev_tr)
               chk(ad_out == prev_ad && phases_left == prev_cnt && lo_take_n && hi_take_n,
                   "R6 wait state hold", {23'd0, phases_left, ad_out}, {23'd0, prev_cnt, prev_ad});
            if (prev_data && !prev_tr)
               chk(phases_left == prev_cnt - 9'd1, "R7 decrement", {55'd0, phases_left}, {55'd0, prev_cnt - 9'd1});
            if (phases_left == 9'd1)
               chk(frame_n && req64_n && lo_take_n && hi_take_n, "R8 last phase frame",
                   {60'd0, frame_n, req64_n, lo_take_n, hi_take_n}, 64'hF);
            else
               chk(!frame_n, "R8 frame held before last", {63'd0, frame_n}, 64'd0);
            trdy_n = ((wmode == 1) && (cyc % 3 == 1)) || ((wmode == 2) && (cyc % 4 != 0));
            prev_data = 1'b1; prev_tr = trdy_n; prev_ad = ad_out; prev_cnt = phases_left;
            cyc++;
         end else begin
            trdy_n = 1'b1; devsel_n = 1'b1; lcl_rdy_n = 1'b1;
            chk(!frame_oe && !ad_oe && !cbe_oe && irdy_oe && phases_left == 9'd0, "R9 release",
                {55'd0, phases_left, frame_oe, ad_oe, cbe_oe, irdy_oe}, 64'h1);
            chk(status == 4'd3 && term_type == 2'd1, "R10 termination status",
                {58'd0, term_type, status}, {58'd0, 2'd1, 4'd3});
            @(negedge clk); #1;
            chk(!irdy_oe, "R9 irdy released", {63'd0, irdy_oe}, 64'd0);
            chk(status == 4'd3 && term_type == 2'd1, "R10 status held", {58'd0, term_type, status}, {58'd0, 2'd1, 4'd3});
            done = 1'b1;
         end
      end
      chk(nlo == nw && nhi == nw - 1, "R5 strobe counts", {32'(nlo), 32'(nhi)}, {32'(nw), 32'(nw - 1)});
      @(negedge clk); #3;
      chk(sb_q.size() == 0, "R5 all halves sent", 64'(sb_q.size()), 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "watchdog expired", 64'd0, 64'd1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) begin
         wmem[i] = '0;
         bmem[i] = '0;
      end
      repeat (3) @(negedge clk);
      #1;
      chk(frame_n && irdy_n && req64_n && lo_take_n && hi_take_n, "R1 reset lines high",
          {59'd0, frame_n, irdy_n, req64_n, lo_take_n, hi_take_n}, 64'h1F);
      chk(!frame_oe && !irdy_oe && !ad_oe && !cbe_oe, "R1 reset released",
          {60'd0, frame_oe, irdy_oe, ad_oe, cbe_oe}, 64'd0);
      chk(status == 4'd0 && term_type == 2'd0 && phases_left == 9'd0, "R1 reset status",
          {49'd0, phases_left, term_type, status}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk); #1;

      run_burst(64'h0000_0000_1234_5670, 3, 1'b0, 0, 1, 1, 32'hC0DE_0001);
      run_burst(64'h0000_0012_8000_0040, 4, 1'b1, 1, 3, 1, 32'hBEEF_0002);
      run_burst(64'h0000_0000_0000_1000, 1, 1'b0, 2, 1, 4, 32'h0BAD_0003);
      run_burst(64'hFFFF_0001_0000_0200, 2, 1'b1, 2, 2, 2, 32'h7777_0004);

      @(negedge clk); #1;
      start = 1'b1; words = 8'd0; dac_req = 1'b0;
      @(negedge clk); #1;
      start = 1'b0;
      chk(!frame_oe && !ad_oe && status == 4'd3, "R11 zero-length start ignored",
          {58'd0, frame_oe, ad_oe, status}, {58'd0, 1'b0, 1'b0, 4'd3});
      @(negedge clk); #1;
      chk(!frame_oe && frame_n && phases_left == 9'd0, "R11 bus stays released",
          {53'd0, frame_oe, frame_n, phases_left}, {53'd0, 1'b0, 1'b1, 9'd0});

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule